// File: doc/BRIEF.md
# Independent Voltage-Triggered Rail Controller

This block drives the gate enables of a small group of power rails. Each rail's gate enable follows that rail's own undervoltage-OK flag, so the block imposes no timed order on turn-on. A designer who wants rails to come up in order chains them outside the block: one rail's output voltage feeds the next rail's undervoltage comparator. A shared active-low reset output is released only after every rail is enabled, every gate reports fully on, and a programmable hold-off has run without interruption.

If one rail loses its undervoltage-OK flag, the shared reset drops and that rail's gate follows its flag. The other rails stay on. Raising the active-low enable starts an orderly shutdown: the reset is forced low and each gate switches off after its own programmed delay. The highest-numbered channel goes first and channel 0 goes last. A gate that has switched off during shutdown stays off until enable is driven low again.

Top module: `rail_trig_ctrl`

## Requirements
- R1: While `arst_n` is low, every bit of `gate_en` is 0 and `rst_out_n` is 0.
- R2: While `enable_n` is low, bit i of `gate_en` takes the value of bit i of `uv_ok` at the next clock edge, whatever the other channels hold.
- R3: "Qualified" means that `enable_n` is low, all `uv_ok` bits are 1, all `gate_en` bits are 1 and all `gate_full` bits are 1. `rst_out_n` goes to 1 at the edge on which the block has sampled the qualified condition on RST_DLY consecutive edges.
- R4: If the qualified condition is lost on any edge, for example when one `gate_full` bit drops, the hold-off count restarts from zero. A full RST_DLY consecutive qualified edges are then needed again.
- R5: When any `uv_ok` bit is 0 at a clock edge, `rst_out_n` is 0 after that edge.
- R6: Losing one channel's `uv_ok` leaves the `gate_en` bits of the other channels unchanged.
- R7: While `enable_n` is high, `rst_out_n` is 0 from the first edge after it was sampled high.
- R8: When `enable_n` is sampled high, the count of consecutive high samples starts at 1 on that first edge. Channel i's gate turns off at the edge on which this count reaches OFF_BASE + (NUM_CH-1-i)*OFF_STEP. Channel NUM_CH-1 therefore turns off first and channel 0 last.
- R9: While `enable_n` is high, a gate that is off stays off even when its `uv_ok` bit is 1. It can turn on again only after `enable_n` returns low.
- R10: During shutdown, a channel whose `uv_ok` bit is 0 turns its gate off at the next edge, before its programmed delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low block reset |
| enable_n | input | 1 | Active-low enable; a rising edge starts shutdown |
| uv_ok | input | NUM_CH | Per-rail flag, 1 when the rail is above its undervoltage threshold |
| gate_full | input | NUM_CH | Per-rail flag, 1 when the gate driver reports full enhancement |
| gate_en | output | NUM_CH | Per-rail gate enable |
| rst_out_n | output | 1 | Shared active-low system reset |

## Verification
The per-channel gate registers are visible directly on `gate_en`, so a wrong gate state appears at the ports one edge after the input that caused it. The two counters are hidden. A hold-off counter that fails to clear or is off by one shows up only as `rst_out_n` rising a cycle early or late, or rising after an interrupted window. A wrong shutdown count shows up as a gate dropping at the wrong edge or in the wrong order. The stimulus therefore interrupts the hold-off window partway through and then checks `rst_out_n` on every cycle up to its release. It also compares every gate on every cycle of the shutdown ramp against a model kept in the bench.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

   // Shutdown delay in cycles for channel idx: the highest channel first.
   function automatic int unsigned off_delay(input int unsigned idx,
                                             input int unsigned nch,
                                             input int unsigned base,
                                             input int unsigned step);
      return base + (nch - 1 - idx) * step;
   endfunction

   function automatic int unsigned cnt_width(input int unsigned maxval);
      return (maxval < 2) ? 1 : $clog2(maxval + 1);
   endfunction

endpackage

// File: rtl/rtc_shut_cnt.sv
module rtc_shut_cnt #(
   parameter int unsigned CW   = 4,
   parameter int unsigned MAXV = 11
) (
   input  logic          clk,
   input  logic          arst_n,
   input  logic          enable_n,
   output logic [CW-1:0] count
);
   localparam logic [CW-1:0] LIM = CW'(MAXV);

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n)
         count <= '0;
      else if (!enable_n)
         count <= '0;
      else if (count != LIM)
         count <= count + 1'b1;
   end

   a_r8_count_clears: assert property (@(posedge clk) disable iff (!arst_n)
      !enable_n |=> (count == '0));
   a_r8_count_bounded: assert property (@(posedge clk) disable iff (!arst_n)
      count <= LIM);
endmodule

// File: rtl/rtc_gate_chan.sv
module rtc_gate_chan #(
   parameter int unsigned CW  = 4,
   parameter int unsigned DLY = 2
) (
   input  logic          clk,
   input  logic          arst_n,
   input  logic          enable_n,
   input  logic          uv_ok,
   input  logic [CW-1:0] sd_count,
   output logic          gate_en
);
   localparam logic [CW-1:0] LAST = CW'(DLY - 1);

   logic keep;
   assign keep = (sd_count < LAST);

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n)
         gate_en <= 1'b0;
      else if (!enable_n)
         gate_en <= uv_ok;
      else
         gate_en <= gate_en & uv_ok & keep;
   end

   a_r2_follow_uv: assert property (@(posedge clk) disable iff (!arst_n)
      !enable_n |=> (gate_en == $past(uv_ok)));
   a_r9_stay_off: assert property (@(posedge clk) disable iff (!arst_n)
      (enable_n && !gate_en) |=> !gate_en);
   a_r10_uv_drop_off: assert property (@(posedge clk) disable iff (!arst_n)
      (enable_n && !uv_ok) |=> !gate_en);
endmodule

// File: rtl/rtc_release_timer.sv
module rtc_release_timer #(
   parameter int unsigned DLY = 150000,
   parameter int unsigned TW  = 18
) (
   input  logic clk,
   input  logic arst_n,
   input  logic ready,
   output logic release_q
);
   localparam logic [TW-1:0] LIM  = TW'(DLY);
   localparam logic [TW-1:0] NEAR = TW'(DLY - 1);

   logic [TW-1:0] run;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         run       <= '0;
         release_q <= 1'b0;
      end else begin
         if (!ready)
            run <= '0;
         else if (run != LIM)
            run <= run + 1'b1;
         release_q <= ready && (run >= NEAR);
      end
   end

   a_r4_drop_on_loss: assert property (@(posedge clk) disable iff (!arst_n)
      !ready |=> !release_q);
   a_r3_rise_needs_ready: assert property (@(posedge clk) disable iff (!arst_n)
      $rose(release_q) |-> $past(ready));
endmodule

// File: rtl/rail_trig_ctrl.sv
module rail_trig_ctrl #(
   parameter int unsigned NUM_CH   = 4,
   parameter int unsigned RST_DLY  = 150000,
   parameter int unsigned OFF_BASE = 1000,
   parameter int unsigned OFF_STEP = 1000
) (
   input  logic              clk,
   input  logic              arst_n,
   input  logic              enable_n,
   input  logic [NUM_CH-1:0] uv_ok,
   input  logic [NUM_CH-1:0] gate_full,
   output logic [NUM_CH-1:0] gate_en,
   output logic              rst_out_n
);
   import rtc_pkg::*;

   localparam int unsigned MAX_OFF = off_delay(0, NUM_CH, OFF_BASE, OFF_STEP);
   localparam int unsigned SCW     = cnt_width(MAX_OFF);
   localparam int unsigned TW      = cnt_width(RST_DLY);

   if (NUM_CH < 1) begin : g_bad_nch
      $error("rail_trig_ctrl: NUM_CH must be at least 1");
   end
   if (RST_DLY < 1) begin : g_bad_rst
      $error("rail_trig_ctrl: RST_DLY must be at least 1");
   end
   if (OFF_BASE < 1) begin : g_bad_off
      $error("rail_trig_ctrl: OFF_BASE must be at least 1");
   end

   logic [SCW-1:0] sd_count;
   logic           ready;

   rtc_shut_cnt #(.CW(SCW), .MAXV(MAX_OFF)) u_shut (
      .clk      (clk),
      .arst_n   (arst_n),
      .enable_n (enable_n),
      .count    (sd_count)
   );

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      rtc_gate_chan #(
         .CW  (SCW),
         .DLY (off_delay(i, NUM_CH, OFF_BASE, OFF_STEP))
      ) u_chan (
         .clk      (clk),
         .arst_n   (arst_n),
         .enable_n (enable_n),
         .uv_ok    (uv_ok[i]),
         .sd_count (sd_count),
         .gate_en  (gate_en[i])
      );
   end

   assign ready = !enable_n && (&uv_ok) && (&gate_en) && (&gate_full);

   rtc_release_timer #(.DLY(RST_DLY), .TW(TW)) u_timer (
      .clk       (clk),
      .arst_n    (arst_n),
      .ready     (ready),
      .release_q (rst_out_n)
   );

   a_r7_reset_while_disabled: assert property (@(posedge clk) disable iff (!arst_n)
      enable_n |=> !rst_out_n);
   a_r5_uv_loss_resets: assert property (@(posedge clk) disable iff (!arst_n)
      !(&uv_ok) |=> !rst_out_n);
   a_r6_others_hold: assert property (@(posedge clk) disable iff (!arst_n)
      (!enable_n && (uv_ok == $past(uv_ok))) |=> (gate_en == $past(uv_ok)));
endmodule

// File: tb/rail_trig_ctrl_tb.sv
module rail_trig_ctrl_tb;
   localparam int CLK_PERIOD = 10;
   localparam int NCH  = 4;
   localparam int RST  = 8;
   localparam int OB   = 2;
   localparam int OS   = 3;

   logic           clk = 1'b0;
   logic           arst_n = 1'b0;
   logic           enable_n = 1'b1;
   logic [NCH-1:0] uv_ok = '0;
   logic [NCH-1:0] gate_full = '0;
   logic [NCH-1:0] gate_en;
   logic           rst_out_n;

   always #(CLK_PERIOD/2) clk = ~clk;

   rail_trig_ctrl #(.NUM_CH(NCH), .RST_DLY(RST), .OFF_BASE(OB), .OFF_STEP(OS)) u_dut (
      .clk(clk), .arst_n(arst_n), .enable_n(enable_n), .uv_ok(uv_ok),
      .gate_full(gate_full), .gate_en(gate_en), .rst_out_n(rst_out_n)
   );

   typedef struct {
      int             due;
      logic [NCH-1:0] gate;
      logic           rst;
      string          tag;
   } exp_t;

   exp_t q[$];
   int cyc = 0;
   int checks = 0;
   int fails = 0;
   bit finished = 0;

   logic [NCH-1:0] mg = '0;
   int rcnt = 0;
   int scnt = 0;

   always @(posedge clk) cyc <= cyc + 1;

   // Monitor: pop every item due in this cycle and compare.
   always @(negedge clk) begin
      while (q.size() > 0 && q[0].due == cyc) begin
         exp_t e;
         e = q.pop_front();
         checks++;
         if (gate_en !== e.gate || rst_out_n !== e.rst) begin
            fails++;
            $display("FAIL %s cycle %0d: gate_en=%b rst_out_n=%b expected gate_en=%b rst_out_n=%b",
                     e.tag, cyc, gate_en, rst_out_n, e.gate, e.rst);
         end
      end
   end

   // Driver: apply one cycle of stimulus and push the expected outcome.
   task automatic step(input logic [NCH-1:0] uv, input logic [NCH-1:0] fh,
                       input logic en, input string tag);
      logic [NCH-1:0] ng;
      logic rdy, nr;
      exp_t e;
      @(posedge clk);
      #1;
      uv_ok = uv; gate_full = fh; enable_n = en;
      rdy = !en && (&uv) && (&mg) && (&fh);
      if (rdy) rcnt = (rcnt < RST) ? rcnt + 1 : rcnt;
      else rcnt = 0;
      nr = rdy && (rcnt >= RST);
      if (!en) begin
         scnt = 0;
         ng = uv;
      end else begin
         scnt++;
         for (int i = 0; i < NCH; i++)
            ng[i] = mg[i] & uv[i] & (scnt < (OB + (NCH - 1 - i) * OS));
      end
      mg = ng;
      e.due = cyc + 1; e.gate = ng; e.rst = nr; e.tag = tag;
      q.push_back(e);
   endtask

   task automatic hold(input int n, input logic [NCH-1:0] uv,
                       input logic [NCH-1:0] fh, input logic en, input string tag);
      for (int k = 0; k < n; k++) step(uv, fh, en, tag);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      checks++;
      if (gate_en !== '0 || rst_out_n !== 1'b0) begin
         fails++;
         $display("FAIL R1 reset: gate_en=%b rst_out_n=%b expected 0000 0", gate_en, rst_out_n);
      end
      uv_ok = 4'b1111;
      enable_n = 1'b0;
      @(negedge clk);
      checks++;
      if (gate_en !== '0 || rst_out_n !== 1'b0) begin
         fails++;
         $display("FAIL R1 reset held: gate_en=%b rst_out_n=%b expected 0000 0", gate_en, rst_out_n);
      end
      uv_ok = '0;
      enable_n = 1'b1;
      @(posedge clk); #1 arst_n = 1'b1;

      hold(2, 4'b0000, 4'b0000, 1'b0, "R1");
      step(4'b0001, 4'b0000, 1'b0, "R2");
      step(4'b0011, 4'b0001, 1'b0, "R2");
      step(4'b0100, 4'b0011, 1'b0, "R2");
      step(4'b1010, 4'b0100, 1'b0, "R2");
      hold(5, 4'b1111, 4'b1111, 1'b0, "R3");
      step(4'b1111, 4'b1011, 1'b0, "R4");
      hold(12, 4'b1111, 4'b1111, 1'b0, "R4");
      step(4'b1101, 4'b1111, 1'b0, "R5");
      hold(3, 4'b1101, 4'b1111, 1'b0, "R6");
      hold(11, 4'b1111, 4'b1111, 1'b0, "R3");
      step(4'b1111, 4'b1111, 1'b1, "R7");
      hold(13, 4'b1111, 4'b1111, 1'b1, "R8");
      hold(3, 4'b1111, 4'b0000, 1'b1, "R9");
      hold(12, 4'b1111, 4'b1111, 1'b0, "R9");
      hold(2, 4'b1111, 4'b1111, 1'b1, "R8");
      step(4'b1011, 4'b1111, 1'b1, "R10");
      hold(10, 4'b1011, 4'b1111, 1'b1, "R10");
      repeat (3) @(posedge clk);
      @(negedge clk);
      if (!finished) begin
         finished = 1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!finished) begin
         finished = 1;
         checks++;
         fails++;
         $display("FAIL watchdog: run did not complete, actual hung expected done");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule